// File: doc/BRIEF.md
# Divided Countdown Interrupt Timer

This block is a local interrupt timer. Software loads a starting count. The block then counts it down, one step for every N ticks of a bus clock, where N is a power of two selected by a 3-bit divide code. When the count runs out, the block records an expiry. It raises an interrupt request carrying an 8-bit vector, unless that request is masked. A control word holds the vector, the mask, a send-pending flag and a periodic flag. With the periodic flag clear, the timer fires once and stops. With it set, the count reloads itself on every expiry.

Expiries are queued in a small saturating counter. The request stays up until one acknowledge has been taken for each queued expiry. A software-enable input acts as a master switch. While it is low, the control word is held masked and every queued expiry is discarded. A single write/read port reaches four locations: the control word, the starting count, the live count (read-only) and the divide configuration.

Top module: `cdown_timer`

## Requirements
- R1: After reset, the control word reads 0x0001_0000 (masked, vector 0, one-shot). The starting count, the live count and the divide configuration read 0, and `irq_req` is low.
- R2: The divide code is {cfg[3], cfg[1:0]} of the word written at location 3. The ratio is 1 << ((code + 1) mod 8), so code 7 divides by 1 and code 0 divides by 2. Bit 2 is dropped and reads back 0.
- R3: The first expiry comes exactly starting-count × ratio bus ticks after the starting count is written. After k ticks, the live count (location 2) reads start − floor(k / ratio).
- R4: Writing a starting count of zero stops the timer. The live count then reads 0 and no expiry follows.
- R5: Writing the starting count (location 1) again while counting restarts from the full period and clears any partial division step.
- R6: With the periodic flag (bit 17) clear, the timer expires once, then stops with the live count at 0.
- R7: With the periodic flag set, each expiry reloads the starting count, so expiries repeat every starting-count × ratio ticks.
- R8: The control word (location 0) keeps only vector bits [7:0], send-pending bit 12, mask bit 16 and periodic bit 17. Every other written bit reads back 0.
- R9: While `sw_en` is low, the mask bit is forced to 1 and queued expiries are dropped. A control word written during that time is stored masked.
- R10: `irq_req` is high exactly when at least one expiry is queued and the mask bit is 0. `irq_vector` is the stored vector. Each cycle with `irq_req` and `irq_ack` both high retires one queued expiry.
- R11: Expiries are queued even while masked or not yet acknowledged, up to 2^PEND_W − 1 (15 by default). When an expiry and a taken acknowledge fall in the same cycle, the queue depth does not change.
- R12: Writes to the live-count location (location 2) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_en | input | 1 | Software enable; low masks the control word and drops queued expiries |
| bus_tick | input | 1 | One bus-clock tick per cycle in which it is high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write location: 0 control, 1 starting count, 2 live count, 3 divide |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 2 | Read location, same map |
| rd_data | output | DATA_W | Read data (combinational) |
| irq_req | output | 1 | Interrupt request |
| irq_vector | output | 8 | Vector carried by the request |
| irq_ack | input | 1 | Acknowledge; retires one queued expiry when taken |

## Verification
The two functions that can collide are a new expiry entering the queue and an acknowledge leaving it in the same cycle. The bench provokes this with a periodic timer and one expiry already queued. It raises `irq_ack` in exactly the cycle of the next expiry, then freezes the bus tick. The queue must still hold exactly one expiry: the request must stay high after that cycle and fall after a single further acknowledge. A design that loses either event, or counts both, fails that check.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

  localparam int unsigned RATIO_W      = 8;
  localparam int unsigned SEND_BIT     = 12;
  localparam int unsigned MASK_BIT     = 16;
  localparam int unsigned PERIODIC_BIT = 17;

  typedef enum logic [1:0] {
    LOC_ENTRY = 2'd0,
    LOC_START = 2'd1,
    LOC_LIVE  = 2'd2,
    LOC_DIV   = 2'd3
  } loc_e;

  typedef struct packed {
    logic       periodic;
    logic       mask;
    logic       send_pend;
    logic [7:0] vector;
  } entry_t;

  // Divide code gathered from the non-contiguous configuration bits.
  function automatic logic [2:0] div_code(input logic [3:0] cfg);
    return {cfg[3], cfg[1:0]};
  endfunction

  // Ratio = 1 << ((code + 1) mod 8); the 3-bit add wraps code 7 to shift 0.
  function automatic logic [RATIO_W-1:0] div_ratio(input logic [2:0] code);
    logic [2:0] sh;
    sh = code + 3'd1;
    return {{(RATIO_W-1){1'b0}}, 1'b1} << sh;
  endfunction

  function automatic entry_t entry_from_word(input logic [31:0] w, input logic force_mask);
    entry_t e;
    e.vector    = w[7:0];
    e.send_pend = w[SEND_BIT];
    e.mask      = w[MASK_BIT] | force_mask;
    e.periodic  = w[PERIODIC_BIT];
    return e;
  endfunction

  function automatic logic [31:0] entry_to_word(input entry_t e);
    logic [31:0] w;
    w               = '0;
    w[7:0]          = e.vector;
    w[SEND_BIT]     = e.send_pend;
    w[MASK_BIT]     = e.mask;
    w[PERIODIC_BIT] = e.periodic;
    return w;
  endfunction

endpackage

// File: rtl/cdt_prescale.sv
module cdt_prescale
  import cdt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               clear,
  input  logic [RATIO_W-1:0] ratio,
  output logic               wrap
);

  localparam logic [RATIO_W-1:0] R_ONE = {{(RATIO_W-1){1'b0}}, 1'b1};

  logic [RATIO_W-1:0] pcnt;
  logic               at_top;

  // ">=" keeps the wrap sane when the ratio shrinks mid-step.
  assign at_top = (pcnt >= (ratio - R_ONE));
  assign wrap   = tick & ~clear & at_top;

  always_ff @(posedge clk) begin
    if (!rst_n)          pcnt <= '0;
    else if (clear)      pcnt <= '0;
    else if (tick)       pcnt <= at_top ? '0 : pcnt + R_ONE;
  end

endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             periodic,
  input  logic             step,
  output logic [CNT_W-1:0] cur,
  output logic             running,
  output logic             expire
);

  localparam logic [CNT_W-1:0] C_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic last_step;

  assign last_step = (cur == C_ONE);
  assign expire    = step & running & last_step & ~load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur     <= '0;
      running <= 1'b0;
    end else if (load) begin
      cur     <= load_val;
      running <= |load_val;
    end else if (step && running) begin
      if (last_step) begin
        if (periodic) begin
          cur     <= reload_val;
          running <= |reload_val;
        end else begin
          cur     <= '0;
          running <= 1'b0;
        end
      end else begin
        cur <= cur - C_ONE;
      end
    end
  end

endmodule

// File: rtl/cdt_pending.sv
module cdt_pending #(
  parameter int unsigned PEND_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              expire,
  input  logic              mask,
  input  logic              ack,
  output logic              irq_req,
  output logic              take,
  output logic [PEND_W-1:0] pend
);

  localparam logic [PEND_W-1:0] P_ONE = {{(PEND_W-1){1'b0}}, 1'b1};
  localparam logic [PEND_W-1:0] P_MAX = '1;

  assign irq_req = (pend != '0) & ~mask;
  assign take    = irq_req & ack;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      pend <= '0;
    end else begin
      unique case ({expire, take})
        2'b10:   if (pend != P_MAX) pend <= pend + P_ONE;
        2'b01:   pend <= pend - P_ONE;
        default: pend <= pend;
      endcase
    end
  end

endmodule

// File: rtl/cdown_timer.sv
module cdown_timer
  import cdt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned PEND_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_en,
  input  logic              bus_tick,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_req,
  output logic [7:0]        irq_vector,
  input  logic              irq_ack
);

  entry_t             ent;
  logic [CNT_W-1:0]   start_q;
  logic [2:0]         code_q;
  logic [RATIO_W-1:0] ratio;

  // Named internal events for the checker.
  logic               wr_entry, wr_div, load;
  logic               presc_wrap, expire, take, running, tmr_periodic, tmr_mask;
  logic [CNT_W-1:0]   cur_cnt;
  logic [PEND_W-1:0]  pend_cnt;

  assign wr_entry     = wr_en && (wr_addr == LOC_ENTRY);
  assign load         = wr_en && (wr_addr == LOC_START);
  assign wr_div       = wr_en && (wr_addr == LOC_DIV);
  assign ratio        = div_ratio(code_q);
  assign tmr_periodic = ent.periodic;
  assign tmr_mask     = ent.mask;
  assign irq_vector   = ent.vector;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent     <= '{periodic: 1'b0, mask: 1'b1, send_pend: 1'b0, vector: 8'h00};
      start_q <= '0;
      code_q  <= '0;
    end else begin
      if (wr_entry) ent <= entry_from_word(wr_data[31:0], ~sw_en);
      if (!sw_en)   ent.mask <= 1'b1;
      if (load)     start_q <= wr_data[CNT_W-1:0];
      if (wr_div)   code_q <= div_code(wr_data[3:0]);
    end
  end

  cdt_prescale u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (bus_tick),
    .clear (load),
    .ratio (ratio),
    .wrap  (presc_wrap)
  );

  cdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .load_val   (wr_data[CNT_W-1:0]),
    .reload_val (start_q),
    .periodic   (ent.periodic),
    .step       (presc_wrap),
    .cur        (cur_cnt),
    .running    (running),
    .expire     (expire)
  );

  cdt_pending #(.PEND_W(PEND_W)) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (sw_en),
    .expire  (expire),
    .mask    (ent.mask),
    .ack     (irq_ack),
    .irq_req (irq_req),
    .take    (take),
    .pend    (pend_cnt)
  );

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      LOC_ENTRY: rd_data = DATA_W'(entry_to_word(ent));
      LOC_START: rd_data = DATA_W'(start_q);
      LOC_LIVE:  rd_data = DATA_W'(cur_cnt);
      default:   rd_data = DATA_W'({code_q[2], 1'b0, code_q[1:0]});
    endcase
  end

endmodule

// File: rtl/cdown_timer_chk.sv
module cdown_timer_chk #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned PEND_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sw_en,
  input logic              irq_req,
  input logic              load,
  input logic [CNT_W-1:0]  load_val,
  input logic              step,
  input logic              expire,
  input logic              take,
  input logic              running,
  input logic              periodic,
  input logic              mask,
  input logic [CNT_W-1:0]  cur,
  input logic [CNT_W-1:0]  start,
  input logic [PEND_W-1:0] pend
);

  localparam logic [CNT_W-1:0]  C_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [PEND_W-1:0] P_ONE = {{(PEND_W-1){1'b0}}, 1'b1};
  localparam logic [PEND_W-1:0] P_MAX = '1;

  p_step_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && running && !load && cur > C_ONE) |=> (cur == $past(cur) - C_ONE));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(cur));

  p_zero_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val == '0) |=> (cur == '0 && !running));

  p_oneshot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !periodic) |=> (cur == '0 && !running));

  p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && periodic) |=> (cur == $past(start)));

  p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_en |=> (!irq_req && mask));

  p_ack_retire_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && take && !expire) |=> (pend == $past(pend) - P_ONE));

  p_queue_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && expire && !take && pend != P_MAX) |=> (pend == $past(pend) + P_ONE));

  p_saturate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && expire && pend == P_MAX) |=> (pend == P_MAX));

  p_same_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && expire && take) |=> $stable(pend));

endmodule

bind cdown_timer cdown_timer_chk #(.CNT_W(CNT_W), .PEND_W(PEND_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sw_en    (sw_en),
  .irq_req  (irq_req),
  .load     (load),
  .load_val (wr_data[CNT_W-1:0]),
  .step     (presc_wrap),
  .expire   (expire),
  .take     (take),
  .running  (running),
  .periodic (tmr_periodic),
  .mask     (tmr_mask),
  .cur      (cur_cnt),
  .start    (start_q),
  .pend     (pend_cnt)
);

// File: tb/sim_cdown_timer.sv
module sim_cdown_timer;

  localparam int DATA_W = 32;
  localparam int CNT_W  = 32;
  localparam int PEND_W = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              sw_en = 1'b0;
  logic              bus_tick = 1'b0;
  logic              wr_en = 1'b0;
  logic [1:0]        wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [1:0]        rd_addr = '0;
  logic [DATA_W-1:0] rd_data;
  logic              irq_req;
  logic [7:0]        irq_vector;
  logic              irq_ack = 1'b0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  cdown_timer #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PEND_W(PEND_W)) u0 (
    .clk(clk), .rst_n(rst_n), .sw_en(sw_en), .bus_tick(bus_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_req(irq_req), .irq_vector(irq_vector), .irq_ack(irq_ack)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ack1;
    @(negedge clk);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  task automatic stop_timer;
    bus_tick = 1'b0;
    wr(2'd1, 32'd0);
  endtask

  // Ratio stated as a lookup: code 7 -> 1, otherwise 2 << code.
  function automatic int ratio_of(input logic [3:0] cfg);
    int c;
    c = {cfg[3], cfg[1:0]};
    if (c == 7) return 1;
    return 2 << c;
  endfunction

  function automatic logic [31:0] ent_word(input logic [7:0] v, input logic m, input logic p);
    return (32'(p) << 17) | (32'(m) << 16) | 32'(v);
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    rd(2'd0, d); chk("R1 control word", d, 32'h0001_0000);
    rd(2'd1, d); chk("R1 start count", d, 32'd0);
    rd(2'd2, d); chk("R1 live count", d, 32'd0);
    rd(2'd3, d); chk("R1 divide cfg", d, 32'd0);
    chk("R1 irq_req", 32'(irq_req), 32'd0);
  endtask

  task automatic t_entry_fields;
    logic [31:0] d;
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); chk("R8 kept fields only", d, 32'h0003_10FF);
    wr(2'd0, 32'h0000_0000);
    rd(2'd0, d); chk("R8 cleared word", d, 32'h0);
  endtask

  task automatic t_divide;
    logic [31:0] d;
    wr(2'd3, 32'hF);
    rd(2'd3, d); chk("R2 bit2 dropped", d, 32'hB);
    wr(2'd3, 32'h4);
    rd(2'd3, d); chk("R2 only bit2 set", d, 32'h0);
  endtask

  task automatic t_period(input logic [3:0] cfg, input int init);
    logic [31:0] d;
    int r, p, a;
    r = ratio_of(cfg);
    p = init * r;
    a = p / 3;
    stop_timer();
    wr(2'd0, ent_word(8'h45, 1'b0, 1'b0));
    wr(2'd3, 32'(cfg));
    bus_tick = 1'b1;
    wr(2'd1, 32'(init));
    edges(a);
    rd(2'd2, d); chk($sformatf("R3 live count cfg=%0h", cfg), d, 32'(init - a / r));
    edges(p - 1 - a);
    chk($sformatf("R3 no early expiry cfg=%0h", cfg), 32'(irq_req), 32'd0);
    rd(2'd2, d); chk($sformatf("R3 last step cfg=%0h", cfg), d, 32'd1);
    edges(1);
    chk($sformatf("R3 expiry on time cfg=%0h", cfg), 32'(irq_req), 32'd1);
    chk("R10 vector", 32'(irq_vector), 32'h45);
    rd(2'd2, d); chk("R6 live count after one-shot", d, 32'd0);
    bus_tick = 1'b0;
    ack1();
    chk("R10 ack retires request", 32'(irq_req), 32'd0);
  endtask

  task automatic t_zero;
    logic [31:0] d;
    stop_timer();
    wr(2'd0, ent_word(8'h10, 1'b0, 1'b1));
    wr(2'd3, 32'hF);
    bus_tick = 1'b1;
    wr(2'd1, 32'd5);
    edges(2);
    wr(2'd1, 32'd0);
    rd(2'd2, d); chk("R4 zero start reads 0", d, 32'd0);
    edges(40);
    chk("R4 no expiry when stopped", 32'(irq_req), 32'd0);
    rd(2'd2, d); chk("R4 stays 0", d, 32'd0);
    bus_tick = 1'b0;
  endtask

  task automatic t_restart;
    logic [31:0] d;
    stop_timer();
    wr(2'd0, ent_word(8'h11, 1'b0, 1'b0));
    wr(2'd3, 32'hF);
    bus_tick = 1'b1;
    wr(2'd1, 32'd10);
    edges(6);
    rd(2'd2, d); chk("R5 before restart", d, 32'd4);
    wr(2'd1, 32'd10);
    rd(2'd2, d); chk("R5 restart full count", d, 32'd10);
    edges(9);
    chk("R5 no expiry before full period", 32'(irq_req), 32'd0);
    edges(1);
    chk("R5 expiry after full period", 32'(irq_req), 32'd1);
    bus_tick = 1'b0;
    ack1();
  endtask

  task automatic t_oneshot;
    logic [31:0] d;
    stop_timer();
    wr(2'd0, ent_word(8'h12, 1'b0, 1'b0));
    wr(2'd3, 32'hF);
    bus_tick = 1'b1;
    wr(2'd1, 32'd3);
    edges(3);
    chk("R6 fires", 32'(irq_req), 32'd1);
    ack1();
    edges(20);
    chk("R6 fires only once", 32'(irq_req), 32'd0);
    rd(2'd2, d); chk("R6 stopped at 0", d, 32'd0);
    bus_tick = 1'b0;
  endtask

  task automatic t_periodic;
    logic [31:0] d;
    stop_timer();
    wr(2'd0, ent_word(8'h21, 1'b0, 1'b1));
    wr(2'd3, 32'hF);
    bus_tick = 1'b1;
    wr(2'd1, 32'd4);
    edges(12);
    bus_tick = 1'b0;
    rd(2'd2, d); chk("R7 reloaded count", d, 32'd4);
    for (int i = 0; i < 3; i++) begin
      chk("R7 queued periodic expiry", 32'(irq_req), 32'd1);
      ack1();
    end
    chk("R7 exactly three expiries", 32'(irq_req), 32'd0);
  endtask

  task automatic t_masked;
    stop_timer();
    wr(2'd0, ent_word(8'h22, 1'b1, 1'b1));
    wr(2'd3, 32'hF);
    bus_tick = 1'b1;
    wr(2'd1, 32'd2);
    edges(6);
    bus_tick = 1'b0;
    chk("R10 masked request low", 32'(irq_req), 32'd0);
    wr(2'd0, ent_word(8'h22, 1'b0, 1'b1));
    for (int i = 0; i < 3; i++) begin
      chk("R11 expiries kept while masked", 32'(irq_req), 32'd1);
      ack1();
    end
    chk("R11 three expiries delivered", 32'(irq_req), 32'd0);
  endtask

  task automatic t_saturate;
    stop_timer();
    wr(2'd0, ent_word(8'h33, 1'b1, 1'b1));
    wr(2'd3, 32'hF);
    bus_tick = 1'b1;
    wr(2'd1, 32'd1);
    edges(20);
    bus_tick = 1'b0;
    wr(2'd0, ent_word(8'h33, 1'b0, 1'b1));
    chk("R10 vector after unmask", 32'(irq_vector), 32'h33);
    for (int i = 0; i < 15; i++) begin
      chk("R11 saturated queue", 32'(irq_req), 32'd1);
      ack1();
    end
    chk("R11 queue capped at 15", 32'(irq_req), 32'd0);
  endtask

  task automatic t_same_cycle;
    stop_timer();
    wr(2'd0, ent_word(8'h52, 1'b0, 1'b1));
    wr(2'd3, 32'hF);
    bus_tick = 1'b1;
    wr(2'd1, 32'd3);
    edges(3);
    chk("R11 first expiry queued", 32'(irq_req), 32'd1);
    edges(2);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    bus_tick = 1'b0;
    chk("R11 expiry and ack same cycle", 32'(irq_req), 32'd1);
    ack1();
    chk("R11 one left after collision", 32'(irq_req), 32'd0);
  endtask

  task automatic t_disable;
    logic [31:0] d;
    stop_timer();
    wr(2'd0, ent_word(8'h61, 1'b0, 1'b1));
    wr(2'd3, 32'hF);
    bus_tick = 1'b1;
    wr(2'd1, 32'd2);
    edges(4);
    bus_tick = 1'b0;
    chk("R9 queued before disable", 32'(irq_req), 32'd1);
    @(negedge clk); sw_en = 1'b0;
    @(negedge clk); sw_en = 1'b1;
    chk("R9 request dropped", 32'(irq_req), 32'd0);
    rd(2'd0, d); chk("R9 mask forced", d, ent_word(8'h61, 1'b1, 1'b1));
    sw_en = 1'b0;
    wr(2'd0, ent_word(8'h61, 1'b0, 1'b1));
    rd(2'd0, d); chk("R9 write stored masked", d, ent_word(8'h61, 1'b1, 1'b1));
    sw_en = 1'b1;
    wr(2'd0, ent_word(8'h61, 1'b0, 1'b1));
    rd(2'd0, d); chk("R9 unmask after enable", d, ent_word(8'h61, 1'b0, 1'b1));
    chk("R9 queue discarded", 32'(irq_req), 32'd0);
  endtask

  task automatic t_live_ro;
    logic [31:0] d;
    stop_timer();
    wr(2'd3, 32'hF);
    wr(2'd1, 32'd100);
    wr(2'd2, 32'h55);
    rd(2'd2, d); chk("R12 live count not writable", d, 32'd100);
    rd(2'd1, d); chk("R12 start count unchanged", d, 32'd100);
    stop_timer();
  endtask

  initial begin
    edges(3);
    rst_n = 1'b1;
    edges(1);
    t_reset();
    sw_en = 1'b1;
    t_entry_fields();
    t_divide();
    t_period(4'h0, 5);
    t_period(4'hF, 3);
    t_period(4'hA, 2);
    t_period(4'h3, 1);
    t_period(4'h8, 3);
    t_zero();
    t_restart();
    t_oneshot();
    t_periodic();
    t_masked();
    t_saturate();
    t_same_cycle();
    t_disable();
    t_live_ro();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule